// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block is the divide execution unit of a 64-bit integer datapath. The issue stage presents a 32-bit instruction word together with the two source register values and raises `start` for one cycle. The unit decodes the instruction and performs an unsigned or a signed divide. It then raises `done` for one cycle. The quotient appears on `result`, and two flags mark encodings the unit rejects. An instruction bit selects either full 64-bit operation or a 32-bit mode that works on the low halves of the operands.

Ordinary quotients come from a radix-2 restoring divider that produces one quotient bit per clock. It works on operand magnitudes, and a final step negates the quotient when the signs call for it. Three kinds of operation skip the iteration and complete one cycle after `start`: a zero divisor, the one signed case whose quotient cannot be represented, and any rejected encoding.

The control is a three-state machine:
- `ST_IDLE` moves to `ST_ITER` on an accepted divide that needs iteration. It stays in `ST_IDLE` for a fast-path operation.
- `ST_ITER` holds for 64 steps and then moves to `ST_FIXUP`.
- `ST_FIXUP` writes the signed, trimmed quotient and returns to `ST_IDLE`.

Top module: `intdiv_unit`

## Requirements
- R1: Instruction fields used:
  - Bit 31 is the width select: 1 means 64-bit, 0 means 32-bit.
  - Bit 29 must be clear for a legal encoding.
  - The opcode sits in bits 15:10. Value 2 is an unsigned divide and value 3 is a signed divide.
- R2: An unsigned divide returns the quotient rounded down (floor).
- R3: A signed divide returns the two's-complement quotient rounded toward zero, so it is negative exactly when the operand signs differ.
- R4: A zero divisor yields a result of 0 for both forms, with no flag raised, and `done` rises one cycle after `start`.
- R5: A signed 64-bit divide of 0x8000000000000000 by all-ones (minus one) returns 0x8000000000000000, and `done` rises one cycle after `start`.
- R6: In 32-bit mode, operand bits 63:32 are ignored. The low halves are sign-extended from bit 31 for the signed form and zero-extended for the unsigned form.
- R7: In 32-bit mode, bits 63:32 of the result are zero for both forms.
- R8: When bit 29 is set, `illegal` is 1 and `unsupported` is 0 at `done`, one cycle after `start`, and `result` keeps its previous value.
- R9: Opcodes 8 to 11 and 16 to 23 (with bit 29 clear) raise `unsupported` and leave `result` unchanged. Every other opcode apart from 2 and 3 raises `illegal`. Both cases finish one cycle after `start`.
- R10: A divide that iterates keeps `busy` high for 65 cycles and raises `done` 66 cycles after the `start` cycle, with `busy` low during `done`.
- R11: A `start` presented while `busy` is high is ignored.
- R12: `done` is high for one cycle per accepted operation. `result`, `illegal` and `unsupported` change only in a `done` cycle.
- R13: A synchronous active-high reset leaves `busy`, `done`, `illegal` and `unsupported` at 0 and `result` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when not busy) |
| insn | input | 32 | Instruction word |
| op_a | input | 64 | Dividend register value |
| op_b | input | 64 | Divisor register value |
| busy | output | 1 | An iterating divide is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Quotient, held until the next completion |
| illegal | output | 1 | Last operation had an unallocated encoding |
| unsupported | output | 1 | Last operation was a recognised but unimplemented opcode |

## Verification
Some internal faults can only show at the ports as a difference in timing:
- A step counter that is off by one moves `done` away from cycle 66.
- A state machine that re-accepts `start` while busy shifts `done` or changes the quotient.

The bench predicts `busy` and `done` on every cycle, so either fault appears on the first cycle the timing differs. A wrong magnitude, sign fix-up or 32-bit trim reaches `result` only in the `done` cycle, where it is compared against quotients computed with native integer arithmetic. Decode faults show one cycle after `start`, through the flags or through a result that changed when it should have held.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        OPK_UDIV,
        OPK_SDIV,
        OPK_UNSUP,
        OPK_ILLEGAL
    } opkind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_FIXUP
    } state_e;

    localparam logic [5:0] OPC_UDIV = 6'd2;
    localparam logic [5:0] OPC_SDIV = 6'd3;

endpackage

// File: rtl/intdiv_decode.sv
module intdiv_decode
    import intdiv_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output opkind_e         kind,
    output logic            wide,
    output logic            neg_quot,
    output logic [XLEN-1:0] mag_n,
    output logic [XLEN-1:0] mag_d,
    output logic            div_zero,
    output logic            sgn_ovf
);
    localparam int unsigned HALF = XLEN / 2;
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    logic [5:0]      opc;
    logic            is_signed;
    logic [XLEN-1:0] ext_n, ext_d;
    logic            sn, sd;

    assign opc  = insn[15:10];
    assign wide = insn[31];

    always_comb begin
        if (insn[29]) begin
            kind = OPK_ILLEGAL;
        end else begin
            case (opc) inside
                OPC_UDIV:                    kind = OPK_UDIV;
                OPC_SDIV:                    kind = OPK_SDIV;
                [6'd8:6'd11], [6'd16:6'd23]: kind = OPK_UNSUP;
                default:                     kind = OPK_ILLEGAL;
            endcase
        end
    end

    assign is_signed = (kind == OPK_SDIV);

    always_comb begin
        if (wide) begin
            ext_n = op_a;
            ext_d = op_b;
        end else if (is_signed) begin
            ext_n = {{HALF{op_a[HALF-1]}}, op_a[HALF-1:0]};
            ext_d = {{HALF{op_b[HALF-1]}}, op_b[HALF-1:0]};
        end else begin
            ext_n = {{HALF{1'b0}}, op_a[HALF-1:0]};
            ext_d = {{HALF{1'b0}}, op_b[HALF-1:0]};
        end
    end

    assign sn       = is_signed & ext_n[XLEN-1];
    assign sd       = is_signed & ext_d[XLEN-1];
    assign mag_n    = sn ? (~ext_n + 1'b1) : ext_n;
    assign mag_d    = sd ? (~ext_d + 1'b1) : ext_d;
    assign neg_quot = sn ^ sd;
    assign div_zero = (ext_d == '0);
    assign sgn_ovf  = is_signed && (ext_n == MOST_NEG) && (ext_d == '1);

endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quotient
);
    logic [XLEN-1:0] rem_q, quo_q, den_q;
    logic [XLEN:0]   shifted, diff;

    assign shifted = {rem_q, quo_q[XLEN-1]};
    assign diff    = shifted - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            den_q <= divisor;
        end else if (step) begin
            if (!diff[XLEN]) begin
                rem_q <= diff[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= shifted[XLEN-1:0];
                quo_q <= {quo_q[XLEN-2:0], 1'b0};
            end
        end
    end

    assign quotient = quo_q;

endmodule

// File: rtl/intdiv_unit.sv
module intdiv_unit
    import intdiv_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            illegal,
    output logic            unsupported
);
    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned CW   = $clog2(XLEN + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(XLEN - 1);
    localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

    state_e          state_q;
    logic [CW-1:0]   cnt_q;
    opkind_e         kind;
    logic            wide, neg_quot, div_zero, sgn_ovf;
    logic [XLEN-1:0] mag_n, mag_d, quotient;
    logic            accept, is_div, go_long;
    logic            neg_r, wide_r;

    function automatic logic [XLEN-1:0] trim(input logic [XLEN-1:0] v, input logic w);
        return w ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    intdiv_decode #(.XLEN(XLEN)) u_decode (
        .insn     (insn),
        .op_a     (op_a),
        .op_b     (op_b),
        .kind     (kind),
        .wide     (wide),
        .neg_quot (neg_quot),
        .mag_n    (mag_n),
        .mag_d    (mag_d),
        .div_zero (div_zero),
        .sgn_ovf  (sgn_ovf)
    );

    assign accept  = start && (state_q == ST_IDLE);
    assign is_div  = (kind == OPK_UDIV) || (kind == OPK_SDIV);
    assign go_long = accept && is_div && !div_zero && !sgn_ovf;

    intdiv_core #(.XLEN(XLEN)) u_core (
        .clk      (clk),
        .load     (go_long),
        .step     (state_q == ST_ITER),
        .dividend (mag_n),
        .divisor  (mag_d),
        .quotient (quotient)
    );

    // State register and step counter
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go_long) begin
                        state_q <= ST_ITER;
                        cnt_q   <= '0;
                    end
                end
                ST_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_q <= ST_FIXUP;
                end
                ST_FIXUP: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            done        <= 1'b0;
            result      <= '0;
            illegal     <= 1'b0;
            unsupported <= 1'b0;
            neg_r       <= 1'b0;
            wide_r      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (go_long) begin
                        neg_r  <= neg_quot;
                        wide_r <= wide;
                    end else if (accept) begin
                        done        <= 1'b1;
                        illegal     <= (kind == OPK_ILLEGAL);
                        unsupported <= (kind == OPK_UNSUP);
                        if (is_div) result <= trim(div_zero ? '0 : MOST_NEG, wide);
                    end
                end
                ST_FIXUP: begin
                    done        <= 1'b1;
                    illegal     <= 1'b0;
                    unsupported <= 1'b0;
                    result      <= trim(neg_r ? (~quotient + 1'b1) : quotient, wide_r);
                end
                default: ;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);

endmodule

// File: rtl/intdiv_unit_chk.sv
module intdiv_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic [31:0]     insn,
    input logic [XLEN-1:0] op_b,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            illegal,
    input logic            unsupported
);
    int unsigned blen;

    always_ff @(posedge clk) begin
        if (rst)       blen <= 0;
        else if (busy) blen <= blen + 1;
        else           blen <= 0;
    end

    assert_no_done_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done && blen == XLEN + 1));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(illegal) && $stable(unsupported)));

    assert_illegal_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && insn[29]) |=> (done && illegal && !unsupported && $stable(result)));

    assert_zero_div_R4: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !insn[29] && insn[15:11] == 5'b00001 && op_b == '0)
        |=> (done && result == '0 && !illegal && !unsupported));

endmodule

bind intdiv_unit intdiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .insn        (insn),
    .op_b        (op_b),
    .busy        (busy),
    .done        (done),
    .result      (result),
    .illegal     (illegal),
    .unsupported (unsupported)
);

// File: tb/intdiv_unit_bench.sv
module intdiv_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        busy, done, illegal, unsupported;
    logic [63:0] result;

    int tests = 0, fails = 0;
    logic [63:0] prev_res = '0;
    bit finished = 0;

    always #2 clk = ~clk;

    intdiv_unit u_intdiv_unit (
        .clk(clk), .rst(rst), .start(start), .insn(insn), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result), .illegal(illegal), .unsupported(unsupported)
    );

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit sf, bit b29, logic [5:0] opc);
        return {sf, 1'b0, b29, 8'b11010110, 5'd1, opc, 5'd2, 5'd3};
    endfunction

    // Behavioural model of the requirements
    function automatic void model(input logic [31:0] ins, input logic [63:0] a, b,
                                  output logic [63:0] res, output bit ill, output bit uns,
                                  output bit fast);
        logic [5:0] opc = ins[15:10];
        bit sf = ins[31];
        longint sn, sd;
        logic [63:0] un, ud;
        res = prev_res; ill = 0; uns = 0; fast = 1;
        if (ins[29]) ill = 1;
        else if (opc == 6'd2) begin
            un = sf ? a : {32'b0, a[31:0]};
            ud = sf ? b : {32'b0, b[31:0]};
            if (ud == 0) res = 0;
            else begin res = un / ud; fast = 0; end
            if (!sf) res[63:32] = 0;
        end else if (opc == 6'd3) begin
            sn = sf ? longint'(a) : longint'({{32{a[31]}}, a[31:0]});
            sd = sf ? longint'(b) : longint'({{32{b[31]}}, b[31:0]});
            if (sd == 0) res = 0;
            else if (sn == 64'sh8000000000000000 && sd == -1) res = 64'h8000000000000000;
            else begin res = 64'(sn / sd); fast = 0; end
            if (!sf) res[63:32] = 0;
        end else if ((opc >= 8 && opc <= 11) || (opc >= 16 && opc <= 23)) uns = 1;
        else ill = 1;
    endfunction

    task automatic run_op(string req, logic [31:0] ins, logic [63:0] a, b, bit poke = 0);
        logic [63:0] er;
        bit ei, eu, fast;
        int lat;
        model(ins, a, b, er, ei, eu, fast);
        lat = fast ? 1 : 66;
        @(negedge clk);
        start = 1; insn = ins; op_a = a; op_b = b;
        for (int cyc = 1; cyc <= lat; cyc++) begin
            @(negedge clk);
            start = 0;
            check(cyc == lat ? req : "R10", "busy", 64'(busy), 64'(cyc < lat));
            check(cyc == lat ? req : "R10", "done", 64'(done), 64'(cyc == lat));
            if (poke && cyc == 5) begin
                // R11: second start while busy must be ignored
                start = 1; insn = mk(1, 0, 6'd2); op_a = 64'd999; op_b = 64'd0;
            end
            if (cyc == lat) begin
                check(req, "result", result, er);
                check(req, "illegal", 64'(illegal), 64'(ei));
                check(req, "unsupported", 64'(unsupported), 64'(eu));
            end
        end
        prev_res = er;
        @(negedge clk);
        check("R12", "done low after pulse", 64'(done), 64'd0);
        check("R12", "result held", result, er);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R13", "busy", 64'(busy), 0);
        check("R13", "done", 64'(done), 0);
        check("R13", "result", result, 0);
        check("R13", "flags", {62'b0, illegal, unsupported}, 0);

        run_op("R1 R2", mk(1, 0, 6'd2), 64'd100, 64'd7);
        run_op("R2", mk(1, 0, 6'd2), 64'hFFFF_FFFF_FFFF_FFFF, 64'd3);
        run_op("R2", mk(1, 0, 6'd2), 64'd5, 64'd9);
        run_op("R1 R3", mk(1, 0, 6'd3), -64'sd100, 64'd7);
        run_op("R3", mk(1, 0, 6'd3), 64'd100, -64'sd7);
        run_op("R3", mk(1, 0, 6'd3), -64'sd100, -64'sd7);
        run_op("R3", mk(1, 0, 6'd3), 64'h8000_0000_0000_0000, 64'd2);
        run_op("R4", mk(1, 0, 6'd2), 64'd77, 64'd0);
        run_op("R4", mk(1, 0, 6'd3), -64'sd77, 64'd0);
        run_op("R5", mk(1, 0, 6'd3), 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R6", mk(0, 0, 6'd3), 64'h1234_5678_FFFF_FF9C, 64'hAAAA_0000_0000_0007);
        run_op("R6", mk(0, 0, 6'd2), 64'hDEAD_BEEF_0000_0064, 64'hFFFF_FFFF_0000_0007);
        run_op("R4 R6", mk(0, 0, 6'd2), 64'd10, 64'hFFFF_FFFF_0000_0000);
        run_op("R7", mk(0, 0, 6'd3), 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R7", mk(0, 0, 6'd3), 64'd100, 64'h0000_0000_FFFF_FFF9);
        run_op("R8", mk(1, 1, 6'd2), 64'd50, 64'd5);
        run_op("R9", mk(1, 0, 6'd9), 64'd50, 64'd5);
        run_op("R9", mk(0, 0, 6'd20), 64'd50, 64'd5);
        run_op("R9", mk(1, 0, 6'd0), 64'd50, 64'd5);
        run_op("R9", mk(1, 0, 6'd24), 64'd50, 64'd5);
        run_op("R11", mk(1, 0, 6'd2), 64'd1000, 64'd10, 1);
        for (int i = 0; i < 8; i++) begin
            run_op("R2 R3", mk(i[0], 0, {5'd1, i[1]}), {$urandom, $urandom}, {32'b0, $urandom} >> i);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule